// File: doc/BRIEF.md
# Accumulator ALU with Packed-Decimal Arithmetic

This unit does the arithmetic and logic work of a small 8-bit accumulator processor in a single registered stage. Each cycle, the sequencer presents an operation code, two operands, the current carry and the decimal-mode setting, and raises `in_valid`. One clock later the block returns the 8-bit result and new values for the negative, zero, carry and overflow flags. Each output has its own write-enable, so the register file and status register update only the fields that the operation actually defines.

Addition and subtraction can run in binary or in packed two-digit decimal. In decimal mode a nibble-wise adjustment is applied to the result. Compare and bit test produce flags only. Shifts, rotates, increment and decrement act on operand `opnd_a`. Registers, sequencing and memory sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 (add) in binary mode returns (a + b + carry_in) mod 256. Carry is set when the sum exceeds 0xFF. Overflow is bit 7 of (a XOR r) AND (b XOR r). All four flag enables and `res_we` are set.
- R2: Add with `bcd_en` high first sums the low nibbles with carry_in. If that sum is ten or more, ten is taken off and 0x10 is carried up. The upper nibbles are then added, and if the total exceeds 0x9F, 0x60 is added. Carry is set when the corrected total exceeds 0xFF. Overflow uses the corrected result in the R1 formula.
- R3: Operation code 1 (subtract) in binary mode returns (a − b − 1 + carry_in) mod 256. Carry is set when no borrow occurs. Overflow is bit 7 of (a XOR r) AND (a XOR b). All four flags and `res_we` are written.
- R4: Subtract with `bcd_en` high works on each nibble separately. A borrow from the low nibble takes 6 off the low digit and 1 off the high digit. A borrow from the high nibble takes 6 off the high digit. Carry and overflow still come from the binary difference.
- R5: Operation code 2 (compare) ignores carry_in and `bcd_en`. The result is a − b, and carry is set when a ≥ b unsigned. N, Z and C are written, and V and `res_we` are not.
- R6: Codes 3, 4 and 5 return a AND b, a OR b and a XOR b. Only N and Z are written.
- R7: Code 6 (bit test) returns a AND b with `res_we` low. N is set from b bit 7, V from b bit 6, and Z is set when a AND b is zero. C is not written.
- R8: Codes 7, 8, 9 and 10 act on a. Code 7 shifts left with bit 7 going to carry. Code 8 shifts right, with bit 0 going to carry and bit 7 cleared. Codes 9 and 10 are the left and right rotates through carry_in. N, Z and C are written.
- R9: Codes 11 (increment) and 12 (decrement) return a ± 1 mod 256 and write only N and Z. Carry_in and `bcd_en` have no effect on them.
- R10: For every written flag, N is result bit 7 (except under R7) and Z is set when the result is zero. A flag output whose enable is low reads 0.
- R11: Outputs appear exactly one clock after `in_valid` is sampled, with `out_valid` high. A cycle without `in_valid` yields `out_valid` low with all enables, flags and the result at zero.
- R12: While `rst_n` is low at a rising edge, every output is cleared to zero.
- R13: Codes 13 to 15 write nothing, and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 4 | Operation selector (see requirements) |
| opnd_a | input | 8 | Accumulator or register operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| bcd_en | input | 1 | Decimal mode for add and subtract |
| out_valid | output | 1 | Registered outputs valid |
| result | output | 8 | Operation result |
| res_we | output | 1 | Result should be written back |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| flag_v | output | 1 | Overflow flag value |
| we_n | output | 1 | Negative flag write-enable |
| we_z | output | 1 | Zero flag write-enable |
| we_c | output | 1 | Carry flag write-enable |
| we_v | output | 1 | Overflow flag write-enable |

## Verification
The bench builds the block only with its default data width of 8. The decimal rules are defined on two 4-bit digits, so this width is the one where every nibble carry, nibble borrow and the 0x9F high-digit adjustment can be hit with specific operand pairs. The vectors also pin the wrap points 0xFF+1 and 0x00−1, signed overflow in both directions, and the case where a decimal add overflows into carry with a zero result.

// File: rtl/acc_alu_pkg.sv
// Package: shared width and the operation encoding for the accumulator ALU.
// Assumes an 8-bit datapath made of two packed-decimal digits.
package acc_alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_BIT = 4'd6,
        OP_ASL = 4'd7,
        OP_LSR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
// Module: combinational adder/subtractor with optional packed-decimal correction.
// Assumes 8-bit operands holding two BCD digits when bcd is set. Carry and
// overflow on subtract always come from the binary difference.
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              bcd,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    logic [DATA_W:0]   bin_add;
    logic [DATA_W:0]   bin_sub;
    logic [DATA_W+1:0] dec_add;
    logic [NIB_W:0]    lo_d;
    logic [NIB_W:0]    hi_d;
    logic [NIB_W:0]    lo_s;
    logic [NIB_W:0]    hi_s;

    // Binary sum and difference (difference as a + ~b + cin; bit 8 = no borrow).
    always_comb begin
        bin_add = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        bin_sub = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, cin};
    end

    // Decimal add: low digit adjust, then high digit adjust past 0x9F.
    always_comb begin
        lo_d = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        if (lo_d >= 5'd10) lo_d = (lo_d - 5'd10) | 5'h10;
        dec_add = {5'b0, lo_d} + {2'b0, a[DATA_W-1:NIB_W], 4'b0}
                               + {2'b0, b[DATA_W-1:NIB_W], 4'b0};
        if (dec_add > 10'h09F) dec_add = dec_add + 10'h060;
    end

    // Decimal subtract: per-digit difference with borrow fix-ups.
    always_comb begin
        lo_s = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - 5'd1 + {{NIB_W{1'b0}}, cin};
        hi_s = {1'b0, a[DATA_W-1:NIB_W]} - {1'b0, b[DATA_W-1:NIB_W]};
        if (lo_s[NIB_W]) begin
            lo_s = lo_s - 5'd6;
            hi_s = hi_s - 5'd1;
        end
        if (hi_s[NIB_W]) hi_s = hi_s - 5'd6;
    end

    // Output select between add/subtract and binary/decimal.
    always_comb begin
        if (sub) begin
            sum  = bcd ? {hi_s[NIB_W-1:0], lo_s[NIB_W-1:0]} : bin_sub[DATA_W-1:0];
            cout = bin_sub[DATA_W];
            ovf  = (a[DATA_W-1] ^ bin_sub[DATA_W-1]) & (a[DATA_W-1] ^ b[DATA_W-1]);
        end else if (bcd) begin
            sum  = dec_add[DATA_W-1:0];
            cout = |dec_add[DATA_W+1:DATA_W];
            ovf  = (a[DATA_W-1] ^ dec_add[DATA_W-1]) & (b[DATA_W-1] ^ dec_add[DATA_W-1]);
        end else begin
            sum  = bin_add[DATA_W-1:0];
            cout = bin_add[DATA_W];
            ovf  = (a[DATA_W-1] ^ bin_add[DATA_W-1]) & (b[DATA_W-1] ^ bin_add[DATA_W-1]);
        end
    end
endmodule

// File: rtl/acc_alu_logshift.sv
// Module: combinational bitwise logic, shifts, rotates and increment/decrement.
// Assumes unary operations act on a; the carry out is meaningful only for shifts.
module acc_alu_logshift
    import acc_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    // Per-operation result and shifted-out bit.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            OP_AND, OP_BIT: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_ASL: begin res = {a[DATA_W-2:0], 1'b0}; cout = a[DATA_W-1]; end
            OP_LSR: begin res = {1'b0, a[DATA_W-1:1]}; cout = a[0];        end
            OP_ROL: begin res = {a[DATA_W-2:0], cin};  cout = a[DATA_W-1]; end
            OP_ROR: begin res = {cin, a[DATA_W-1:1]};  cout = a[0];        end
            OP_INC:         res = a + 8'd1;
            OP_DEC:         res = a - 8'd1;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
// Module: single-stage registered ALU for an 8-bit accumulator machine.
// Decodes the operation, picks the arithmetic or logic path, builds the flag
// values and their write-enables, and registers everything for one cycle.
// Assumes a synchronous active-low reset and one request per cycle at most.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic              bcd_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              res_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              we_n,
    output logic              we_z,
    output logic              we_c,
    output logic              we_v
);
    alu_op_e           op;
    logic              is_cmp;
    logic [DATA_W-1:0] as_sum;
    logic              as_c;
    logic              as_v;
    logic [DATA_W-1:0] ls_res;
    logic              ls_c;
    logic [DATA_W-1:0] nx_res;
    logic              nx_rw, nx_wn, nx_wz, nx_wc, nx_wv;
    logic              nx_n, nx_z, nx_c, nx_v;
    logic              raw_c, raw_v;

    assign op     = alu_op_e'(op_code);
    assign is_cmp = (op == OP_CMP);

    acc_alu_addsub u_addsub (
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (is_cmp ? 1'b1 : carry_in),
        .bcd  (bcd_en & ~is_cmp),
        .sub  (op != OP_ADD),
        .sum  (as_sum),
        .cout (as_c),
        .ovf  (as_v)
    );

    acc_alu_logshift u_logshift (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (carry_in),
        .res  (ls_res),
        .cout (ls_c)
    );

    // Operation decode: result source and which outputs are written.
    always_comb begin
        nx_res = '0;
        nx_rw  = 1'b0;
        nx_wn  = 1'b0; nx_wz = 1'b0; nx_wc = 1'b0; nx_wv = 1'b0;
        raw_c  = 1'b0; raw_v = 1'b0;
        if (in_valid) begin
            case (op)
                OP_ADD, OP_SUB: begin
                    nx_res = as_sum; nx_rw = 1'b1;
                    nx_wn = 1'b1; nx_wz = 1'b1; nx_wc = 1'b1; nx_wv = 1'b1;
                    raw_c = as_c; raw_v = as_v;
                end
                OP_CMP: begin
                    nx_res = as_sum;
                    nx_wn = 1'b1; nx_wz = 1'b1; nx_wc = 1'b1;
                    raw_c = as_c;
                end
                OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                    nx_res = ls_res; nx_rw = 1'b1;
                    nx_wn = 1'b1; nx_wz = 1'b1;
                end
                OP_BIT: begin
                    nx_res = ls_res;
                    nx_wn = 1'b1; nx_wz = 1'b1; nx_wv = 1'b1;
                    raw_v = opnd_b[DATA_W-2];
                end
                OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                    nx_res = ls_res; nx_rw = 1'b1;
                    nx_wn = 1'b1; nx_wz = 1'b1; nx_wc = 1'b1;
                    raw_c = ls_c;
                end
                default: ;
            endcase
        end
    end

    // Flag values, forced to zero where the enable is low.
    always_comb begin
        nx_n = nx_wn & ((op == OP_BIT) ? opnd_b[DATA_W-1] : nx_res[DATA_W-1]);
        nx_z = nx_wz & (nx_res == '0);
        nx_c = nx_wc & raw_c;
        nx_v = nx_wv & raw_v;
    end

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; result <= '0; res_we <= 1'b0;
            flag_n <= 1'b0; flag_z <= 1'b0; flag_c <= 1'b0; flag_v <= 1'b0;
            we_n <= 1'b0; we_z <= 1'b0; we_c <= 1'b0; we_v <= 1'b0;
        end else begin
            out_valid <= in_valid; result <= nx_res; res_we <= nx_rw;
            flag_n <= nx_n; flag_z <= nx_z; flag_c <= nx_c; flag_v <= nx_v;
            we_n <= nx_wn; we_z <= nx_wz; we_c <= nx_wc; we_v <= nx_wv;
        end
    end

    // R11
    out_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(res_we | we_n | we_z | we_c | we_v));

    // R10
    unwritten_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((!we_n && flag_n) || (!we_z && flag_z) || (!we_c && flag_c) || (!we_v && flag_v)));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_z |-> (flag_z == (result == '0)));

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_CMP) |=> (!res_we && !we_v && we_c));

    // R9
    incdec_nz_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> (!we_c && !we_v && we_n && we_z));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] op_code;
    logic [7:0] opnd_a, opnd_b;
    logic       carry_in, bcd_en;
    logic       out_valid, res_we;
    logic [7:0] result;
    logic       flag_n, flag_z, flag_c, flag_v, we_n, we_z, we_c, we_v;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .bcd_en(bcd_en),
        .out_valid(out_valid), .result(result), .res_we(res_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .we_n(we_n), .we_z(we_z), .we_c(we_c), .we_v(we_v)
    );

    // {op, a, b, cin, bcd, res, NZCV, weNZCV, res_we}
    localparam int NV = 22;
    localparam logic [38:0] VEC [NV] = '{
        {4'h0, 8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 4'b1001, 4'b1111, 1'b1}, // R1 signed overflow
        {4'h0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0110, 4'b1111, 1'b1}, // R1 wrap to zero
        {4'h0, 8'h19, 8'h28, 1'b1, 1'b1, 8'h48, 4'b0000, 4'b1111, 1'b1}, // R2 low digit adjust
        {4'h0, 8'h99, 8'h01, 1'b0, 1'b1, 8'h00, 4'b0110, 4'b1111, 1'b1}, // R2 high digit adjust
        {4'h1, 8'h50, 8'hB0, 1'b1, 1'b0, 8'hA0, 4'b1001, 4'b1111, 1'b1}, // R3 borrow + overflow
        {4'h1, 8'h05, 8'h05, 1'b1, 1'b0, 8'h00, 4'b0110, 4'b1111, 1'b1}, // R3 equal
        {4'h1, 8'h42, 8'h15, 1'b1, 1'b1, 8'h27, 4'b0010, 4'b1111, 1'b1}, // R4 low borrow
        {4'h1, 8'h10, 8'h20, 1'b1, 1'b1, 8'h90, 4'b1000, 4'b1111, 1'b1}, // R4 high borrow
        {4'h2, 8'h30, 8'h40, 1'b0, 1'b1, 8'hF0, 4'b1000, 4'b1110, 1'b0}, // R5 less than
        {4'h2, 8'h40, 8'h40, 1'b0, 1'b0, 8'h00, 4'b0110, 4'b1110, 1'b0}, // R5 equal
        {4'h3, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, 4'b0100, 4'b1100, 1'b1}, // R6 and
        {4'h4, 8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 4'b1000, 4'b1100, 1'b1}, // R6 or
        {4'h5, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00, 4'b0100, 4'b1100, 1'b1}, // R6 xor
        {4'h6, 8'h01, 8'hC0, 1'b0, 1'b0, 8'h00, 4'b1101, 4'b1101, 1'b0}, // R7 high bits set
        {4'h6, 8'hFF, 8'h3F, 1'b1, 1'b0, 8'h3F, 4'b0000, 4'b1101, 1'b0}, // R7 high bits clear
        {4'h7, 8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 4'b0010, 4'b1110, 1'b1}, // R8 shift left
        {4'h8, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 4'b0110, 4'b1110, 1'b1}, // R8 shift right
        {4'h9, 8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 4'b0010, 4'b1110, 1'b1}, // R8 rotate left
        {4'hA, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 4'b1010, 4'b1110, 1'b1}, // R8 rotate right
        {4'hB, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h00, 4'b0100, 4'b1100, 1'b1}, // R9 increment wrap
        {4'hC, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b1000, 4'b1100, 1'b1}, // R9 decrement wrap
        {4'hF, 8'h5A, 8'h33, 1'b1, 1'b1, 8'h00, 4'b0000, 4'b0000, 1'b0}  // R13 undefined code
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1:   return "R1";
            2, 3:   return "R2";
            4, 5:   return "R3";
            6, 7:   return "R4";
            8, 9:   return "R5";
            10, 11, 12: return "R6";
            13, 14: return "R7";
            15, 16, 17, 18: return "R8";
            19, 20: return "R9";
            default: return "R13";
        endcase
    endfunction

    // Compare the full registered output word {valid,res,NZCV,weNZCV,res_we}.
    task automatic check_out(string tag, logic ev, logic [7:0] er, logic [3:0] ef,
                             logic [3:0] ew, logic erw);
        logic [17:0] act, exp;
        act = {out_valid, result, flag_n, flag_z, flag_c, flag_v, we_n, we_z, we_c, we_v, res_we};
        exp = {ev, er, ef, ew, erw};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c, logic d);
        @(negedge clk);
        in_valid = v; op_code = op; opnd_a = a; opnd_b = b; carry_in = c; bcd_en = d;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0;
        carry_in = 1'b0; bcd_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_out("R12 reset state", 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][38:35], VEC[i][34:27], VEC[i][26:19], VEC[i][18], VEC[i][17]);
            check_out(tag_of(i), 1'b1, VEC[i][16:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
        end

        // R11: idle cycle after a valid one clears everything
        drive(1'b0, 4'h0, 8'hFF, 8'hFF, 1'b1, 1'b0);
        check_out("R11 idle", 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0);

        // R11: back-to-back requests each appear one cycle later
        drive(1'b1, 4'h0, 8'h01, 8'h02, 1'b0, 1'b0);
        check_out("R11 first", 1'b1, 8'h03, 4'b0000, 4'b1111, 1'b1);
        drive(1'b1, 4'h1, 8'h01, 8'h02, 1'b1, 1'b0);
        check_out("R11 second", 1'b1, 8'hFF, 4'b1000, 4'b1111, 1'b1);

        // R2: decimal add producing carry with non-zero result
        drive(1'b1, 4'h0, 8'h58, 8'h46, 1'b0, 1'b1);
        check_out("R2 carry out", 1'b1, 8'h04, 4'b0010, 4'b1111, 1'b1);

        // R9: carry_in and bcd_en have no effect on increment
        drive(1'b1, 4'hB, 8'h7F, 8'h00, 1'b0, 1'b0);
        check_out("R9 inc plain", 1'b1, 8'h80, 4'b1000, 4'b1100, 1'b1);
        drive(1'b1, 4'hB, 8'h7F, 8'h00, 1'b1, 1'b1);
        check_out("R9 inc ignores cin/bcd", 1'b1, 8'h80, 4'b1000, 4'b1100, 1'b1);

        // R10: N follows result bit 7 for a shift
        drive(1'b1, 4'h7, 8'h40, 8'h00, 1'b0, 1'b0);
        check_out("R10 n from result", 1'b1, 8'h80, 4'b1000, 4'b1110, 1'b1);

        // R12: reset while a request is pending clears outputs
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; op_code = 4'h4; opnd_a = 8'hAA; opnd_b = 8'h55;
        @(posedge clk);
        #1;
        check_out("R12 mid-run reset", 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        @(posedge clk);
        #1;

        finish_run();
    end
endmodule